// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small 8-bit microcontroller core and chooses which of eleven interrupt slots the core should service next. Each slot has a pending flag, an enable bit and a priority bit (0 = low, 1 = high). A global enable gates all of them. The controller samples the qualified requests every clock and picks one winner. At an instruction boundary it presents the winner to the core as a request line and a vector address.

The core answers with a one-cycle acknowledge when it takes the vector, and with a one-cycle return strobe when a service routine ends. From these two strobes the controller keeps one in-service bit per level. The bits decide which levels may interrupt the running routine: a high-level request can interrupt a low-level routine, and nothing can interrupt a high-level one. After a return, the controller waits until one more instruction has completed before it presents another vector. Each source clears its own pending flag; this block never does.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A slot requests only when its pending flag, its enable bit and the global enable are all 1. Slot 8 is reserved and never requests.
- R2: After reset, `irq_o` is 0, `vec_o` is 0x0000 and both in-service outputs are 0.
- R3: When requests at both levels are eligible, a high-level request (priority bit 1) is chosen over every low-level one.
- R4: Within one level, the slot with the lowest index wins. Index 0 ranks highest.
- R5: While `irq_o` is 1, `vec_o` equals 0x0003 + 8 × index of the selected slot. While `irq_o` is 0, `vec_o` is 0x0000.
- R6: A high-level request is presented while only the low in-service bit is set. No request is presented while the high in-service bit is set.
- R7: A request waits while a routine of its own level or higher is in service.
- R8: An acknowledge sets the in-service bit of the presented level. A return clears the high bit if it is set, and the low bit otherwise. `act_lo_o` and `act_hi_o` show these bits.
- R9: A request is registered for one clock before it can be presented. It is then presented only in a cycle where `instr_done_i` is 1, so `irq_o` rises two clock edges after the pending flag is set.
- R10: Once presented, `irq_o` and `vec_o` stay unchanged until `ack_i`, even if a better request arrives meanwhile.
- R11: After `reti_i`, no vector is presented at the boundary that coincides with the return, nor at the next boundary. Presentation is allowed again from the boundary after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | 11 | Pending flag per slot |
| en_i | input | 11 | Enable bit per slot |
| prio_i | input | 11 | Priority per slot, 1 = high |
| gie_i | input | 1 | Global interrupt enable |
| instr_done_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt executed |
| ack_i | input | 1 | Core has taken the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Vector address of the presented slot |
| act_lo_o | output | 1 | Low-level routine in service |
| act_hi_o | output | 1 | High-level routine in service |

## Verification
The bench first serves every usable slot alone, one at a time, so that each vector address is matched to its index. It then raises several requests together to separate the two tie rules: two low-level slots, one low against one high, and two high-level slots. Further runs raise requests while a routine is in service, to tell legal preemption apart from blocking at an equal or higher level. The last runs step the instruction boundary by hand, which shows the one-clock detection delay, gating by the boundary, stability until acknowledge, and the hold-off of one instruction after a return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC      = 11;
  localparam int RSVD_IDX   = 8;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int ADDR_W     = 16;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N        = irq_pkg::N_SRC,
  parameter int RSVD_IDX = irq_pkg::RSVD_IDX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] prio_i,
  input  logic         gie_i,
  output logic [N-1:0] req_lo_o,
  output logic [N-1:0] req_hi_o
);
  localparam logic [N-1:0] KEEP = ~({{(N-1){1'b0}}, 1'b1} << RSVD_IDX);

  logic [N-1:0] live;
  assign live = pend_i & en_i & {N{gie_i}} & KEEP;

  // one detection clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_lo_o <= '0;
      req_hi_o <= '0;
    end else begin
      req_lo_o <= live & ~prio_i;
      req_hi_o <= live & prio_i;
    end
  end

  a_r1_gie_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> (req_lo_o == '0) && (req_hi_o == '0));
  a_r1_rsvd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_lo_o[RSVD_IDX] && !req_hi_o[RSVD_IDX]);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = irq_pkg::N_SRC,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest index is written last
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (valid_o) a_r4_lowest_set: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           take_i,
  input  irq_pkg::lvl_e  take_lvl_i,
  input  logic           reti_i,
  output logic           act_lo_o,
  output logic           act_hi_o
);
  import irq_pkg::*;

  logic lo_d, hi_d;

  // return clears first, acknowledge sets after
  always_comb begin
    lo_d = act_lo_o;
    hi_d = act_hi_o;
    if (reti_i) begin
      if (act_hi_o) hi_d = 1'b0;
      else          lo_d = 1'b0;
    end
    if (take_i) begin
      if (take_lvl_i == LVL_HI) hi_d = 1'b1;
      else                      lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_lo_o <= 1'b0;
      act_hi_o <= 1'b0;
    end else begin
      act_lo_o <= lo_d;
      act_hi_o <= hi_d;
    end
  end

  a_r8_take_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (take_lvl_i == LVL_HI) |=> act_hi_o);
  a_r8_take_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (take_lvl_i == LVL_LO) |=> act_lo_o);
  a_r8_reti_hi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !take_i && act_hi_o |=> !act_hi_o && (act_lo_o == $past(act_lo_o)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N          = irq_pkg::N_SRC,
  parameter int RSVD_IDX   = irq_pkg::RSVD_IDX,
  parameter int VEC_BASE   = irq_pkg::VEC_BASE,
  parameter int VEC_STRIDE = irq_pkg::VEC_STRIDE,
  parameter int ADDR_W     = irq_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      en_i,
  input  logic [N-1:0]      prio_i,
  input  logic              gie_i,
  input  logic              instr_done_i,
  input  logic              reti_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              act_lo_o,
  output logic              act_hi_o
);
  localparam int IDX_W = $clog2(N);
  localparam int NLVL  = 2;

  logic [N-1:0]     req_lvl [NLVL];
  logic [NLVL-1:0]  lvl_vld;
  logic [IDX_W-1:0] lvl_idx [NLVL];

  irq_qualify #(.N(N), .RSVD_IDX(RSVD_IDX)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .prio_i  (prio_i),
    .gie_i   (gie_i),
    .req_lo_o(req_lvl[LVL_LO]),
    .req_hi_o(req_lvl[LVL_HI])
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    irq_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
      .req_i  (req_lvl[l]),
      .valid_o(lvl_vld[l]),
      .idx_o  (lvl_idx[l])
    );
  end

  logic             irq_q, hold_q;
  logic [IDX_W-1:0] idx_q;
  lvl_e             lvl_q;
  logic             take;

  // eligibility against in-service state
  logic             cand_vld;
  logic [IDX_W-1:0] cand_idx;
  lvl_e             cand_lvl;
  always_comb begin
    cand_vld = 1'b0;
    cand_idx = '0;
    cand_lvl = LVL_LO;
    if (lvl_vld[LVL_HI] && !act_hi_o) begin
      cand_vld = 1'b1;
      cand_idx = lvl_idx[LVL_HI];
      cand_lvl = LVL_HI;
    end else if (lvl_vld[LVL_LO] && !act_hi_o && !act_lo_o) begin
      cand_vld = 1'b1;
      cand_idx = lvl_idx[LVL_LO];
    end
  end

  logic present;
  assign present = instr_done_i && !hold_q && !reti_i && cand_vld && !irq_q;
  assign take    = irq_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= LVL_LO;
      hold_q <= 1'b0;
    end else begin
      if (reti_i)                 hold_q <= 1'b1;
      else if (instr_done_i)      hold_q <= 1'b0;
      if (take) irq_q <= 1'b0;
      else if (present) begin
        irq_q <= 1'b1;
        idx_q <= cand_idx;
        lvl_q <= cand_lvl;
      end
    end
  end

  irq_inservice u_isr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .take_lvl_i(lvl_q),
    .reti_i    (reti_i),
    .act_lo_o  (act_lo_o),
    .act_hi_o  (act_hi_o)
  );

  assign irq_o = irq_q;
  assign vec_o = irq_q ? ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(idx_q) : '0;

  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o && $stable(vec_o));
  a_r9_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o ##1 irq_o |-> $past(instr_done_i));
  a_r6_hi_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_hi_o && !irq_o |=> !irq_o);
  a_r11_reti_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !irq_o |=> !irq_o);
  a_r5_idle_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int N = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pend = '0, en = '1, prio = '0;
  logic          gie = 1'b1, instr_done = 1'b1, reti = 1'b0, ack = 1'b0;
  logic          irq;
  logic [15:0]   vec;
  logic          act_lo, act_hi;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          seen = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend), .en_i(en), .prio_i(prio),
    .gie_i(gie), .instr_done_i(instr_done), .reti_i(reti), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .act_lo_o(act_lo), .act_hi_o(act_hi)
  );

  function automatic logic [15:0] vec_of(int idx);
    return 16'(3 + 8 * idx);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_vec(int idx, string tag);
    exp_q.push_back(vec_of(idx));
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: compare each new presentation
  always @(negedge clk) begin
    if (rst_ni && irq && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) check("unexpected irq", int'(vec), 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(vec), int'(e));
      end
    end else if (!irq) seen = 1'b0;
  end

  task automatic wait_irq(string tag);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) return;
    end
    check({tag, " irq timeout"}, 0, 1);
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
  endtask

  task automatic idle_check(string tag, int cyc);
    repeat (cyc) @(negedge clk);
    check(tag, int'(irq), 0);
  endtask

  initial begin
    #2_000_000;
    check("watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 irq", int'(irq), 0);
    check("R2 vec", int'(vec), 0);
    check("R2 act", int'({act_hi, act_lo}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 one detection clock then presentation
    pend = 11'b1;
    expect_vec(0, "R9 R5 slot0");
    @(negedge clk); check("R9 not yet", int'(irq), 0);
    @(negedge clk); check("R9 presented", int'(irq), 1);
    do_ack();
    check("R8 ack sets lo", int'({act_hi, act_lo}), 1);
    pend = '0;
    do_reti();
    check("R8 reti clears lo", int'({act_hi, act_lo}), 0);

    // R5 every usable vector
    for (int i = 1; i < N; i++) begin
      if (i == 8) continue;
      @(negedge clk) pend = N'(1) << i;
      expect_vec(i, "R5 vector");
      wait_irq("R5");
      do_ack();
      pend = '0;
      do_reti();
    end

    // R1 qualification
    @(negedge clk) pend = N'(1) << 8;
    idle_check("R1 reserved slot 8", 5);
    pend = N'(1) << 3; en = '0;
    idle_check("R1 enable off", 5);
    en = '1; gie = 1'b0;
    idle_check("R1 global off", 5);
    pend = '0; gie = 1'b1;

    // R4 tie within low level
    @(negedge clk) pend = (N'(1) << 3) | (N'(1) << 5);
    expect_vec(3, "R4 low tie");
    wait_irq("R4"); do_ack(); pend = '0; do_reti();
    // R3 high over low
    @(negedge clk) begin pend = (N'(1) << 2) | (N'(1) << 6); prio = N'(1) << 6; end
    expect_vec(6, "R3 high wins");
    wait_irq("R3"); do_ack(); pend = '0; do_reti(); prio = '0;
    // R4 tie within high level
    @(negedge clk) begin pend = (N'(1) << 9) | (N'(1) << 10); prio = pend; end
    expect_vec(9, "R4 high tie");
    wait_irq("R4h"); do_ack(); pend = '0; do_reti(); prio = '0;

    // R7, R6 nesting
    @(negedge clk) pend = N'(1) << 4;
    expect_vec(4, "R7 low served");
    wait_irq("R7"); do_ack();
    check("R8 lo only", int'({act_hi, act_lo}), 1);
    pend = N'(1) << 5;
    idle_check("R7 equal level waits", 5);
    pend = (N'(1) << 5) | (N'(1) << 1); prio = N'(1) << 1;
    expect_vec(1, "R6 high preempts");
    wait_irq("R6"); do_ack();
    check("R8 hi set", int'({act_hi, act_lo}), 3);
    pend = (N'(1) << 5) | (N'(1) << 0); prio = N'(1) << 0;
    idle_check("R6 nothing preempts high", 5);
    expect_vec(0, "R6 after high return");
    do_reti();
    check("R8 reti clears hi first", int'({act_hi, act_lo}), 1);
    wait_irq("R6b"); do_ack();
    pend = N'(1) << 5; prio = '0;
    do_reti();
    idle_check("R7 low still blocked", 4);
    expect_vec(5, "R7 low after lo return");
    do_reti();
    wait_irq("R7b");
    // R10 stable until ack
    pend = (N'(1) << 5) | (N'(1) << 0); prio = N'(1) << 0;
    repeat (4) @(negedge clk);
    check("R10 vec held", int'(vec), int'(vec_of(5)));
    check("R10 irq held", int'(irq), 1);
    pend = '0; prio = '0;
    do_ack();

    // R11 post-return hold-off, boundary stepped by hand
    instr_done = 1'b0;
    pend = N'(1) << 7;
    expect_vec(7, "R11 after one instruction");
    do_reti();
    check("R11 none at return", int'(irq), 0);
    @(negedge clk) instr_done = 1'b1;
    @(negedge clk) instr_done = 1'b0;
    check("R11 none after first boundary", int'(irq), 0);
    repeat (3) @(negedge clk);
    check("R9 waits for boundary", int'(irq), 0);
    @(negedge clk) instr_done = 1'b1;
    @(negedge clk) instr_done = 1'b0;
    check("R11 presented at second boundary", int'(irq), 1);
    do_ack(); pend = '0; instr_done = 1'b1; do_reti();
    repeat (3) @(negedge clk);

    check("queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule